// File: doc/BRIEF.md
# Descriptor-Driven Configuration Transfer Engine

This block moves bytes between system memory and a store of numbered configuration items. A host starts it by handing over the 64-bit memory address of a 16-byte descriptor. The engine reads the descriptor and, if asked, selects a new item first. It then performs one of four actions:

- copy item bytes out to memory;
- zero-fill memory past the end of the item;
- step over item bytes without touching memory;
- copy memory bytes into a writable item.

When it is done, it overwrites the descriptor's control word with a completion status.

The host sees a small register window. Writes to the window deliver the descriptor address. Reads return a fixed 64-bit ASCII identification value. The engine reaches memory through a simple request/acknowledge master that moves one byte per request and can report an error response. It reaches the item store through a port that selects an item, reads or writes the byte at the store's current offset (which then increments), or advances that offset by a count. The store reports the validity, length, offset and writability of the current item.

Top module: `cfgdma_engine`

## Requirements
- R1: After reset, `busy` is low, `mem_req` is low and `host_rdata` is zero.
- R2: Window writes behave by size and offset:
  - A 4-byte write at offset 0 only stores its value as the upper half of the descriptor address.
  - A 4-byte write at offset 4 ORs its value into the lower half and starts a transfer.
  - An 8-byte write at offset 0 loads the whole address and starts a transfer.
  - Any other write has no effect.
- R3: The held upper address half is cleared when a transfer starts, so a later offset-4 write alone addresses memory below 4 GiB.
- R4: The descriptor sits at the doorbell address, and all of its fields are big-endian:
  - The 32-bit control word is at +0, the 32-bit length at +4 and the 64-bit memory address at +8.
  - Control bits: 0x01 error, 0x02 read, 0x04 skip, 0x08 select, 0x10 write.
  - With select set, control bits 31:16 are applied as the item key before any data moves, and this resets the item offset.
- R5: The move bits are honoured in the order read, then write, then skip. With none of them set, no data moves and the status is zero.
- R6: A read copies item bytes to consecutive memory addresses starting at the offset. The number copied is the smaller of the remaining length and the item bytes left, and the item offset advances by that number.
- R7: Once the item is exhausted, or when no valid item is selected, a read writes zero bytes for the rest of the length and stops exactly at the end of the length.
- R8: A skip advances the item offset by the smaller of the length and the item bytes left, with no data traffic. Any excess length is dropped without error.
- R9: A write copies memory bytes into the item only if the item is writable and has at least the requested length left. Otherwise it sets the error status and changes no item byte.
- R10: A write to an exhausted or invalid item sets the error status.
- R11: On completion, the 4-byte big-endian status 0x00000000 or 0x00000001 is written at descriptor +0. An error response on any data access ends the transfer with status 1. A failed descriptor fetch writes status 1.
- R12: A window read of S bytes (1, 2, 4 or 8) at offset A returns the identification value shifted right by (8-A-S)*8 bits, keeping the low S bytes. A read that would pass offset 8 returns zero. `host_rdata` is updated the cycle after the read.
- R13: `busy` rises the cycle after a starting write and falls only after the status write completes. Window writes while `busy` is high have no effect, and no memory request is made while `busy` is low.
- R14: Each memory request moves one byte, and its request, address and direction hold steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Window access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Byte offset in the window |
| host_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| host_wdata | input | 64 | Write data, right-aligned |
| host_rdata | output | 64 | Registered read data |
| busy | output | 1 | Transfer pending or running |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = store byte, 0 = load byte |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 8 | Store data |
| mem_ack | input | 1 | Request completed |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 8 | Load data, valid with `mem_ack` |
| st_sel | output | 1 | Select item `st_key`, offset reset to 0 |
| st_key | output | 16 | Item key for a select |
| st_rd | output | 1 | Consume byte at offset (offset + 1) |
| st_wr | output | 1 | Write `st_wdata` at offset (offset + 1) |
| st_wdata | output | 8 | Item write data |
| st_adv | output | 1 | Advance offset by `st_adv_cnt` |
| st_adv_cnt | output | 32 | Offset advance amount |
| st_valid | input | 1 | Current item exists |
| st_len | input | 32 | Current item length |
| st_off | input | 32 | Current item offset |
| st_wen | input | 1 | Current item is writable |
| st_rdata | input | 8 | Item byte at current offset |

## Verification
Two functions can fall in the same cycle: the host window keeps accepting accesses while a transfer drives memory and the item store. The bench provokes this by starting a long zero-fill and then, while it runs, ringing a second doorbell for a descriptor that would otherwise be visible in memory. The second request is judged lost when its descriptor control word is left unrewritten and its target byte untouched, while the first fill ends exactly at its length. Item-side ordering is judged by reading items back through the engine itself after skips and writes.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
  localparam int AW = 64;            // descriptor/memory address width
  localparam int LW = 32;            // length and offset width
  localparam int KW = 16;            // item key width
  localparam int DESC_BYTES = 16;
  localparam int STAT_BYTES = 4;
  localparam int IDX_W = $clog2(DESC_BYTES);

  localparam logic [31:0] CB_READ  = 32'h02;
  localparam logic [31:0] CB_SKIP  = 32'h04;
  localparam int          CB_SEL_BIT = 3;
  localparam logic [31:0] CB_WRITE = 32'h10;

  typedef enum logic [1:0] {MV_NONE, MV_READ, MV_WRITE, MV_SKIP} move_e;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_DECODE, S_SELECT, S_LOOP, S_ITEM_RD, S_MEM_WR,
    S_MEM_RD, S_ITEM_WR, S_ADV, S_ZERO, S_STATUS
  } state_e;

  // read beats write beats skip
  function automatic move_e pick_move(input logic [31:0] ctl);
    if ((ctl & CB_READ) != 0)       return MV_READ;
    else if ((ctl & CB_WRITE) != 0) return MV_WRITE;
    else if ((ctl & CB_SKIP) != 0)  return MV_SKIP;
    else                            return MV_NONE;
  endfunction
endpackage

// File: rtl/cfgdma_window.sv
module cfgdma_window #(
  parameter logic [63:0] SIGNATURE = 64'h4346_4744_4D41_3031
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_en,
  input  logic        host_we,
  input  logic [2:0]  host_addr,
  input  logic [3:0]  host_size,
  input  logic [63:0] host_wdata,
  input  logic        engine_busy,
  output logic [63:0] host_rdata,
  output logic        start,
  output logic [63:0] start_addr
);
  logic [63:0] hi_q;
  logic        wr_ok;
  logic [3:0]  span;
  logic        size_ok;
  logic [6:0]  shamt;
  logic [63:0] mask;
  logic [63:0] sig_slice;

  assign wr_ok = host_en && host_we && !engine_busy && !start;

  always_comb begin
    span    = {1'b0, host_addr} + host_size;
    size_ok = (host_size == 4'd1 || host_size == 4'd2 || host_size == 4'd4 ||
               host_size == 4'd8) && (span <= 4'd8);
    shamt   = {4'd8 - span, 3'b000};
    mask    = (host_size == 4'd8) ? '1 : ((64'd1 << {host_size[2:0], 3'b000}) - 64'd1);
    sig_slice = size_ok ? ((SIGNATURE >> shamt) & mask) : 64'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q       <= '0;
      start      <= 1'b0;
      start_addr <= '0;
      host_rdata <= '0;
    end else begin
      start <= 1'b0;
      if (wr_ok) begin
        if (host_size == 4'd4 && host_addr == 3'd0) begin
          hi_q <= {host_wdata[31:0], 32'h0};
        end else if (host_size == 4'd4 && host_addr == 3'd4) begin
          start      <= 1'b1;
          start_addr <= hi_q | {32'h0, host_wdata[31:0]};
          hi_q       <= '0;
        end else if (host_size == 4'd8 && host_addr == 3'd0) begin
          start      <= 1'b1;
          start_addr <= host_wdata;
          hi_q       <= '0;
        end
      end
      if (host_en && !host_we) host_rdata <= sig_slice;
    end
  end
endmodule

// File: rtl/cfgdma_span.sv
module cfgdma_span #(
  parameter int LW = 32
) (
  input  logic          st_valid,
  input  logic [LW-1:0] st_len,
  input  logic [LW-1:0] st_off,
  input  logic [LW-1:0] want_len,
  output logic          has_bytes,
  output logic [LW-1:0] chunk,
  output logic          short_chunk
);
  logic [LW-1:0] avail;

  always_comb begin
    has_bytes   = st_valid && (st_off < st_len);
    avail       = st_len - st_off;
    chunk       = (want_len <= avail) ? want_len : avail;
    short_chunk = (chunk != want_len);
  end
endmodule

// File: rtl/cfgdma_seq.sv
module cfgdma_seq
  import cfgdma_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [7:0]    mem_rdata,
  output logic          st_sel,
  output logic [KW-1:0] st_key,
  output logic          st_rd,
  output logic          st_wr,
  output logic [7:0]    st_wdata,
  output logic          st_adv,
  output logic [LW-1:0] st_adv_cnt,
  input  logic          st_wen,
  input  logic [7:0]    st_rdata,
  input  logic          has_bytes,
  input  logic [LW-1:0] chunk,
  input  logic          short_chunk,
  output logic [LW-1:0] want_len
);
  state_e                  state;
  move_e                   mv;
  logic [DESC_BYTES*8-1:0] desc;
  logic [AW-1:0]           base;
  logic [AW-1:0]           addr_q;
  logic [LW-1:0]           len_q;
  logic [LW-1:0]           cnt_q;
  logic [LW-1:0]           chunk_q;
  logic                    err_q;
  logic [7:0]              byte_q;
  logic [IDX_W-1:0]        idx_q;
  logic [AW-1:0]           idx_ext;

  assign idx_ext  = {{(AW-IDX_W){1'b0}}, idx_q};
  assign want_len = len_q;
  assign busy     = (state != S_IDLE);

  always_comb begin
    mem_req = (state == S_FETCH) || (state == S_MEM_WR) || (state == S_MEM_RD) ||
              (state == S_ZERO)  || (state == S_STATUS);
    mem_we  = (state == S_MEM_WR) || (state == S_ZERO) || (state == S_STATUS);
    mem_addr = ((state == S_FETCH) || (state == S_STATUS)) ? (base + idx_ext) : addr_q;
    case (state)
      S_MEM_WR: mem_wdata = byte_q;
      S_STATUS: mem_wdata = (idx_q == IDX_W'(STAT_BYTES - 1)) ? {7'd0, err_q} : 8'd0;
      default:  mem_wdata = 8'd0;
    endcase
    st_sel     = (state == S_SELECT);
    st_key     = desc[DESC_BYTES*8-1 -: KW];
    st_rd      = (state == S_ITEM_RD);
    st_wr      = (state == S_ITEM_WR);
    st_wdata   = byte_q;
    st_adv     = (state == S_ADV);
    st_adv_cnt = chunk_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      mv      <= MV_NONE;
      desc    <= '0;
      base    <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      chunk_q <= '0;
      err_q   <= 1'b0;
      byte_q  <= '0;
      idx_q   <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          base  <= start_addr;
          idx_q <= '0;
          err_q <= 1'b0;
          state <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          if (mem_err) begin
            err_q <= 1'b1;
            idx_q <= '0;
            state <= S_STATUS;
          end else begin
            desc  <= {desc[DESC_BYTES*8-9:0], mem_rdata};
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_W'(DESC_BYTES - 1)) state <= S_DECODE;
          end
        end
        S_DECODE: begin
          mv     <= pick_move(desc[127:96]);
          len_q  <= (pick_move(desc[127:96]) == MV_NONE) ? '0 : desc[95:64];
          addr_q <= desc[63:0];
          state  <= desc[96 + CB_SEL_BIT] ? S_SELECT : S_LOOP;
        end
        S_SELECT: state <= S_LOOP;
        S_LOOP: begin
          if (err_q || len_q == '0) begin
            idx_q <= '0;
            state <= S_STATUS;
          end else begin
            case (mv)
              MV_READ: begin
                if (has_bytes) begin
                  cnt_q <= chunk;
                  state <= S_ITEM_RD;
                end else begin
                  state <= S_ZERO;
                end
              end
              MV_SKIP: begin
                if (has_bytes) begin
                  chunk_q <= chunk;
                  state   <= S_ADV;
                end else begin
                  idx_q <= '0;
                  state <= S_STATUS;
                end
              end
              MV_WRITE: begin
                if (!has_bytes) begin
                  err_q <= 1'b1;
                  idx_q <= '0;
                  state <= S_STATUS;
                end else if (!st_wen || short_chunk) begin
                  err_q   <= 1'b1;
                  chunk_q <= chunk;
                  state   <= S_ADV;
                end else begin
                  cnt_q <= chunk;
                  state <= S_MEM_RD;
                end
              end
              default: begin
                idx_q <= '0;
                state <= S_STATUS;
              end
            endcase
          end
        end
        S_ITEM_RD: begin
          byte_q <= st_rdata;
          state  <= S_MEM_WR;
        end
        S_MEM_WR: if (mem_ack) begin
          if (mem_err) begin
            err_q <= 1'b1;
            state <= S_LOOP;
          end else begin
            addr_q <= addr_q + 1'b1;
            len_q  <= len_q - 1'b1;
            cnt_q  <= cnt_q - 1'b1;
            state  <= (cnt_q == LW'(1)) ? S_LOOP : S_ITEM_RD;
          end
        end
        S_MEM_RD: if (mem_ack) begin
          if (mem_err) begin
            err_q <= 1'b1;
            state <= S_LOOP;
          end else begin
            byte_q <= mem_rdata;
            state  <= S_ITEM_WR;
          end
        end
        S_ITEM_WR: begin
          addr_q <= addr_q + 1'b1;
          len_q  <= len_q - 1'b1;
          cnt_q  <= cnt_q - 1'b1;
          state  <= (cnt_q == LW'(1)) ? S_LOOP : S_MEM_RD;
        end
        S_ADV: begin
          addr_q <= addr_q + {{(AW-LW){1'b0}}, chunk_q};
          len_q  <= len_q - chunk_q;
          state  <= S_LOOP;
        end
        S_ZERO: if (mem_ack) begin
          if (mem_err) begin
            err_q <= 1'b1;
            state <= S_LOOP;
          end else begin
            addr_q <= addr_q + 1'b1;
            len_q  <= len_q - 1'b1;
            if (len_q == LW'(1)) state <= S_LOOP;
          end
        end
        S_STATUS: if (mem_ack) begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(STAT_BYTES - 1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
  import cfgdma_pkg::*;
#(
  parameter logic [63:0] SIGNATURE = 64'h4346_4744_4D41_3031
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_en,
  input  logic        host_we,
  input  logic [2:0]  host_addr,
  input  logic [3:0]  host_size,
  input  logic [63:0] host_wdata,
  output logic [63:0] host_rdata,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [7:0]  mem_rdata,
  output logic        st_sel,
  output logic [15:0] st_key,
  output logic        st_rd,
  output logic        st_wr,
  output logic [7:0]  st_wdata,
  output logic        st_adv,
  output logic [31:0] st_adv_cnt,
  input  logic        st_valid,
  input  logic [31:0] st_len,
  input  logic [31:0] st_off,
  input  logic        st_wen,
  input  logic [7:0]  st_rdata
);
  logic          start;
  logic [AW-1:0] start_addr;
  logic          seq_busy;
  logic          has_bytes;
  logic [LW-1:0] chunk;
  logic          short_chunk;
  logic [LW-1:0] want_len;

  assign busy = seq_busy || start;

  cfgdma_window #(.SIGNATURE(SIGNATURE)) u_win (
    .clk(clk), .rst(rst), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .engine_busy(seq_busy), .host_rdata(host_rdata),
    .start(start), .start_addr(start_addr)
  );

  cfgdma_span #(.LW(LW)) u_span (
    .st_valid(st_valid), .st_len(st_len), .st_off(st_off), .want_len(want_len),
    .has_bytes(has_bytes), .chunk(chunk), .short_chunk(short_chunk)
  );

  cfgdma_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .busy(seq_busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .st_sel(st_sel), .st_key(st_key), .st_rd(st_rd), .st_wr(st_wr),
    .st_wdata(st_wdata), .st_adv(st_adv), .st_adv_cnt(st_adv_cnt),
    .st_wen(st_wen), .st_rdata(st_rdata), .has_bytes(has_bytes),
    .chunk(chunk), .short_chunk(short_chunk), .want_len(want_len)
  );
endmodule

// File: rtl/cfgdma_chk.sv
module cfgdma_chk (
  input logic        clk,
  input logic        rst,
  input logic        host_en,
  input logic        host_we,
  input logic [2:0]  host_addr,
  input logic [3:0]  host_size,
  input logic        busy,
  input logic        mem_req,
  input logic        mem_we,
  input logic [63:0] mem_addr,
  input logic        mem_ack,
  input logic        st_sel,
  input logic        st_rd,
  input logic        st_wr,
  input logic        st_adv,
  input logic        st_valid,
  input logic [31:0] st_len,
  input logic [31:0] st_off,
  input logic        st_wen
);
  AST_FULL_DOORBELL_STARTS: assert property (@(posedge clk) disable iff (rst)
    (host_en && host_we && host_size == 4'd8 && host_addr == 3'd0 && !busy) |=> busy); // R2
  AST_HIGH_HALF_ONLY_LATCHES: assert property (@(posedge clk) disable iff (rst)
    (host_en && host_we && host_size == 4'd4 && host_addr == 3'd0 && !busy) |=> !busy); // R2
  AST_IDLE_NO_TRAFFIC: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R13
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R14
  AST_ONE_STORE_OP: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st_sel, st_rd, st_wr, st_adv})); // R6
  AST_READ_INSIDE_ITEM: assert property (@(posedge clk) disable iff (rst)
    st_rd |-> (st_valid && st_off < st_len)); // R6
  AST_WRITE_ALLOWED: assert property (@(posedge clk) disable iff (rst)
    st_wr |-> (st_wen && st_valid && st_off < st_len)); // R9
endmodule

bind cfgdma_engine cfgdma_chk u_chk (
  .clk(clk), .rst(rst), .host_en(host_en), .host_we(host_we),
  .host_addr(host_addr), .host_size(host_size), .busy(busy),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .st_sel(st_sel), .st_rd(st_rd), .st_wr(st_wr), .st_adv(st_adv),
  .st_valid(st_valid), .st_len(st_len), .st_off(st_off), .st_wen(st_wen)
);

// File: tb/sim_cfgdma_engine.sv
`timescale 1ns/1ps
module sim_cfgdma_engine;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] SIG = 64'h4346_4744_4D41_3031;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        host_en = 1'b0, host_we = 1'b0;
  logic [2:0]  host_addr = '0;
  logic [3:0]  host_size = '0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic        busy, mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        mem_ack, mem_err;
  logic        st_sel, st_rd, st_wr, st_adv, st_valid, st_wen;
  logic [15:0] st_key;
  logic [7:0]  st_wdata, st_rdata;
  logic [31:0] st_adv_cnt, st_len, st_off;

  cfgdma_engine #(.SIGNATURE(SIG)) u0 (.*);

  // behavioural memory: one byte per request, ack one cycle later
  logic [7:0] mem [0:255];
  int n_hs = 0;
  function automatic logic bad_addr(input logic [63:0] a);
    return (a[63:8] != 0) || (a[7:0] >= 8'hE4 && a[7:0] <= 8'hEF);
  endfunction
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
    end else begin
      if (mem_req && mem_ack) begin
        n_hs = n_hs + 1;
        if (mem_we && !mem_err) mem[mem_addr[7:0]] = mem_wdata;
      end
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[7:0]];
        mem_err   <= bad_addr(mem_addr);
      end
    end
  end

  // behavioural item store: keys 0..3 exist
  logic [7:0]  itm [0:3][0:15];
  logic [31:0] ilen [0:3];
  logic        iwen [0:3];
  logic [15:0] cur_key;
  logic [31:0] off;
  assign st_valid = cur_key < 16'd4;
  assign st_len   = st_valid ? ilen[cur_key[1:0]] : 32'd0;
  assign st_wen   = st_valid ? iwen[cur_key[1:0]] : 1'b0;
  assign st_off   = off;
  assign st_rdata = itm[cur_key[1:0]][off[3:0]];
  always @(posedge clk) begin
    if (rst) begin
      cur_key <= '0; off <= '0;
    end else if (st_sel) begin
      cur_key <= st_key; off <= '0;
    end else if (st_rd) begin
      off <= off + 1;
    end else if (st_wr) begin
      itm[cur_key[1:0]][off[3:0]] = st_wdata;
      off <= off + 1;
    end else if (st_adv) begin
      off <= off + st_adv_cnt;
    end
  end

  int n_chk = 0, n_err = 0;
  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic init_items();
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < 16; i++) itm[k][i] = 8'((k + 1) * 16 + i);
    ilen[0] = 4; iwen[0] = 1'b0;
    ilen[1] = 8; iwen[1] = 1'b1;
    ilen[2] = 3; iwen[2] = 1'b0;
    ilen[3] = 0; iwen[3] = 1'b0;
  endtask

  task automatic fill(input int a, input int n, input logic [7:0] v);
    for (int i = 0; i < n; i++) mem[(a + i) & 255] = v;
  endtask

  task automatic put_desc(input int b, input logic [31:0] ctl, input logic [31:0] len,
                          input logic [63:0] tgt);
    for (int i = 0; i < 4; i++) mem[b + i] = ctl[31 - 8*i -: 8];
    for (int i = 0; i < 4; i++) mem[b + 4 + i] = len[31 - 8*i -: 8];
    for (int i = 0; i < 8; i++) mem[b + 8 + i] = tgt[63 - 8*i -: 8];
  endtask

  function automatic logic [31:0] word_at(input int b);
    return {mem[b], mem[b+1], mem[b+2], mem[b+3]};
  endfunction

  task automatic host_wr(input logic [2:0] a, input logic [3:0] s, input logic [63:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b1; host_addr = a; host_size = s; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] a, input logic [3:0] s, output logic [63:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b0; host_addr = a; host_size = s;
    @(posedge clk);
    @(negedge clk);
    host_en = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check("busy clears", 64'(busy), 64'd0);
  endtask

  task automatic xfer(input int b, input logic [31:0] ctl, input logic [31:0] len,
                      input logic [63:0] tgt);
    put_desc(b, ctl, len, tgt);
    host_wr(3'd0, 4'd8, 64'(b));
    wait_idle();
  endtask

  task automatic t_reset();
    check("R1 busy", 64'(busy), 0);
    check("R1 mem_req", 64'(mem_req), 0);
    check("R1 host_rdata", host_rdata, 0);
  endtask

  task automatic t_signature();
    logic [63:0] d;
    host_rd(3'd0, 4'd8, d); check("R12 A0 S8", d, 64'h4346_4744_4D41_3031);
    host_rd(3'd0, 4'd4, d); check("R12 A0 S4", d, 64'h4346_4744);
    host_rd(3'd4, 4'd4, d); check("R12 A4 S4", d, 64'h4D41_3031);
    host_rd(3'd2, 4'd2, d); check("R12 A2 S2", d, 64'h4744);
    host_rd(3'd7, 4'd1, d); check("R12 A7 S1", d, 64'h31);
    host_rd(3'd6, 4'd4, d); check("R12 past end", d, 64'h0);
  endtask

  task automatic t_read();
    int hs0;
    init_items(); fill(8'h40, 16, 8'hEE);
    hs0 = n_hs;
    xfer(8'h00, 32'h0000_000A, 3, 64'h40);
    check("R14 byte handshakes", 64'(n_hs - hs0), 64'd23);
    check("R4 R6 copy", {mem[8'h40], mem[8'h41], mem[8'h42]}, 24'h101112);
    check("R6 stop at length", 64'(mem[8'h43]), 64'hEE);
    check("R11 status ok", 64'(word_at(0)), 0);
    xfer(8'h10, 32'h0000_0002, 4, 64'h48);
    check("R6 R7 tail then zeros", word_at(8'h48), 32'h1300_0000);
    check("R7 fill ends", 64'(mem[8'h4C]), 64'hEE);
    check("R11 status ok 2", 64'(word_at(8'h10)), 0);
  endtask

  task automatic t_split();
    init_items(); fill(8'h40, 32, 8'hEE);
    host_wr(3'd0, 4'd4, 64'h0);
    check("R2 high half no start", 64'(busy), 0);
    host_wr(3'd4, 4'd8, 64'h20);
    check("R2 bad size ignored", 64'(busy), 0);
    host_wr(3'd0, 4'd2, 64'h20);
    check("R2 bad size ignored 2", 64'(busy), 0);
    put_desc(8'h20, 32'h0002_000A, 2, 64'h50);
    host_wr(3'd4, 4'd4, 64'h20);
    check("R2 low half starts", 64'(busy), 1);
    wait_idle();
    check("R2 split run", {mem[8'h50], mem[8'h51]}, 16'h3031);
    // R3: a held high half must vanish once a transfer starts
    host_wr(3'd0, 4'd4, 64'h1);
    xfer(8'h30, 32'h0000_000A, 1, 64'h58);
    check("R3 first run", 64'(mem[8'h58]), 64'h10);
    put_desc(8'h60, 32'h0002_000A, 1, 64'h5A);
    host_wr(3'd4, 4'd4, 64'h60);
    wait_idle();
    check("R3 high half cleared", 64'(mem[8'h5A]), 64'h30);
    check("R3 status", 64'(word_at(8'h60)), 0);
  endtask

  task automatic t_busy();
    logic [63:0] d;
    init_items(); fill(8'h40, 48, 8'hEE);
    put_desc(8'h00, 32'h0003_000A, 20, 64'h40);
    put_desc(8'h10, 32'h0000_000A, 1, 64'h60);
    host_wr(3'd0, 4'd8, 64'h00);
    check("R13 busy after doorbell", 64'(busy), 1);
    host_wr(3'd0, 4'd8, 64'h10);
    host_rd(3'd0, 4'd8, d);
    check("R12 read while running", d, SIG);
    wait_idle();
    check("R7 zero fill", 64'(mem[8'h53]), 64'h00);
    check("R7 fill boundary", 64'(mem[8'h54]), 64'hEE);
    check("R13 ignored target", 64'(mem[8'h60]), 64'hEE);
    check("R13 ignored descriptor", 64'(word_at(8'h10)), 64'h0000_000A);
  endtask

  task automatic t_priority();
    init_items(); fill(8'h40, 32, 8'hEE);
    xfer(8'h00, 32'h0002_001E, 2, 64'h40);
    check("R5 read wins", {mem[8'h40], mem[8'h41]}, 16'h3031);
    mem[8'h44] = 8'hA5; mem[8'h45] = 8'h5A;
    xfer(8'h00, 32'h0001_001C, 2, 64'h44);
    check("R5 write over skip status", 64'(word_at(0)), 0);
    xfer(8'h00, 32'h0001_000A, 3, 64'h48);
    check("R5 write wins", {mem[8'h48], mem[8'h49], mem[8'h4A]}, 24'hA55A22);
    xfer(8'h00, 32'h0000_0000, 5, 64'h50);
    check("R5 no move bits status", 64'(word_at(0)), 0);
    check("R5 no move bits memory", 64'(mem[8'h50]), 64'hEE);
  endtask

  task automatic t_skip();
    init_items(); fill(8'h40, 16, 8'hEE);
    xfer(8'h00, 32'h0001_000C, 3, 64'h0);
    check("R8 skip status", 64'(word_at(0)), 0);
    xfer(8'h00, 32'h0000_0002, 2, 64'h40);
    check("R8 skip advanced", {mem[8'h40], mem[8'h41]}, 16'h2324);
    xfer(8'h00, 32'h0002_000C, 20, 64'h0);
    check("R8 excess skip no error", 64'(word_at(0)), 0);
    xfer(8'h00, 32'h0000_0002, 1, 64'h42);
    check("R8 item exhausted", 64'(mem[8'h42]), 64'h00);
  endtask

  task automatic t_write();
    init_items(); fill(8'h40, 32, 8'hEE);
    {mem[8'h40], mem[8'h41], mem[8'h42], mem[8'h43]} = 32'h0102_0304;
    xfer(8'h00, 32'h0001_0018, 4, 64'h40);
    check("R9 write status", 64'(word_at(0)), 0);
    xfer(8'h00, 32'h0001_000A, 5, 64'h48);
    check("R9 written bytes", {mem[8'h48], mem[8'h49], mem[8'h4A], mem[8'h4B], mem[8'h4C]},
          40'h01020304_24);
    xfer(8'h00, 32'h0002_0018, 1, 64'h40);
    check("R9 read-only error", 64'(word_at(0)), 1);
    xfer(8'h00, 32'h0002_000A, 1, 64'h50);
    check("R9 read-only unchanged", 64'(mem[8'h50]), 64'h30);
    init_items();
    xfer(8'h00, 32'h0001_0018, 9, 64'h40);
    check("R9 too long error", 64'(word_at(0)), 1);
    xfer(8'h00, 32'h0001_000A, 1, 64'h51);
    check("R9 too long unchanged", 64'(mem[8'h51]), 64'h20);
    xfer(8'h00, 32'h0007_0018, 1, 64'h40);
    check("R10 invalid item error", 64'(word_at(0)), 1);
    xfer(8'h00, 32'h0000_000C, 4, 64'h0);
    xfer(8'h00, 32'h0000_0010, 1, 64'h40);
    check("R10 exhausted item error", 64'(word_at(0)), 1);
    xfer(8'h00, 32'h0007_000A, 3, 64'h58);
    check("R7 invalid item zeros", {mem[8'h58], mem[8'h59], mem[8'h5A], mem[8'h5B]}, 32'h0000_00EE);
  endtask

  task automatic t_memerr();
    init_items();
    xfer(8'h00, 32'h0000_000A, 2, 64'h1_0000_0000);
    check("R11 data error", 64'(word_at(0)), 1);
    xfer(8'hE0, 32'h0000_000A, 2, 64'h40);
    check("R11 fetch error", 64'(word_at(8'hE0)), 1);
    xfer(8'h00, 32'h0003_000A, 4, 64'hE8);
    check("R11 zero-fill error", 64'(word_at(0)), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    init_items();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_signature();
    t_read();
    t_split();
    t_busy();
    t_priority();
    t_skip();
    t_write();
    t_memerr();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule